// File: doc/BRIEF.md
# Memory LCD Serial Update Controller

This block drives the transmit-only serial link of a one-bit-per-pixel memory LCD. A host hands it one of three commands over a valid/ready handshake. The commands are a full-frame refresh, a blank-the-panel command and a freeze-the-image command. The block frames each command as a chip-select window of 8-bit transfers. The serial clock idles low and data is valid on the rising edge, most significant bit first. The block also places the required quiet time around each window.

For a frame refresh, the block walks every panel row in turn. For each row it sends a bit-reversed, bottom-counted line address, then the row's bytes in descending byte order, then a filler byte. It reads the bytes from an external frame-buffer read port that has one cycle of latency. A separate free-running generator produces the panel's common-electrode toggle pulse. This generator never interacts with transfers. A single enable output turns on the panel supply once reset has been released.

Top module: `memlcd_ctrl`

## Requirements
- R1: While reset is held, lcd_cs, lcd_sclk, lcd_si, lcd_vcom and lcd_en are all low.
- R2: Each byte is shifted out MSB first. lcd_sclk idles low and stays high for exactly CLK_DIV/2 clocks per bit. lcd_si changes only while lcd_sclk is low.
- R3: Command code 0 (frame) produces one chip-select window containing 0x80, then for each row a line group, then a final 0x00. A line group is an address byte, LINE_BYTES data bytes and a 0x00 byte.
- R4: Rows are sent in ascending order 0..LINES-1. The address byte for row i is the 8-bit value LINES-i with its bit order reversed.
- R5: Data bytes of a row are read through fb_row/fb_byte/fb_rd_en, with fb_data valid one clock after fb_rd_en. They are sent from byte index LINE_BYTES-1 down to 0. fb_rd_en is asserted only while lcd_cs is high.
- R6: Command code 1 (clear) produces one window containing exactly 0x20, 0x00.
- R7: Command code 2 (freeze) produces one window containing exactly 0x00, 0x00, 0x00.
- R8: Command code 3 is accepted and discarded: no window opens and the block stays ready.
- R9: At least SETUP_CYC clocks pass from the rise of lcd_cs to the first lcd_sclk rise. At least HOLD_CYC clocks pass from the last lcd_sclk fall to the fall of lcd_cs. lcd_cs stays low for at least GAP_CYC clocks between windows.
- R10: A command is taken on a clock where cmd_valid and cmd_ready are both high. cmd_ready equals the inverse of busy. A command offered while busy is held off and executed afterwards. lcd_cs never rises without an acceptance on the previous clock.
- R11: lcd_vcom rises every VCOM_PRE*VCOM_TICKS clocks and stays high for exactly VCOM_PRE clocks, whatever transfers are in progress.
- R12: lcd_en is high from the first clocks after reset release onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_code | input | 2 | 0 frame, 1 clear, 2 freeze, 3 none |
| cmd_ready | output | 1 | Command can be taken this clock |
| busy | output | 1 | A transaction or its quiet time is in progress |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_row | output | ROW_W | Row index of the read |
| fb_byte | output | BYTE_W | Byte index of the read |
| fb_data | input | 8 | Read data, valid one clock after fb_rd_en |
| lcd_sclk | output | 1 | Serial clock |
| lcd_si | output | 1 | Serial data |
| lcd_cs | output | 1 | Active-high chip select |
| lcd_vcom | output | 1 | Common-electrode toggle pulse |
| lcd_en | output | 1 | Panel supply enable |

## Verification
A corrupted field or row counter shows up at once in the decoded byte stream. The bad byte appears in the same window as a wrong address, a wrong byte order or a wrong count of bytes, so a single frame reveals it. A wrong wait count appears as a setup, hold or gap interval that is too short, measured on the very next window. A broken divider in the pulse generator shows up as a wrong pulse interval within one period. The bench decodes the serial stream from the pins alone and compares every byte of every window against a stream built arithmetically. It does this for several frame-buffer patterns, each command code, and a command queued behind a busy block.

// File: rtl/memlcd_pkg.sv
package memlcd_pkg;

  typedef enum logic [1:0] {
    CMD_FRAME  = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_FREEZE = 2'd2,
    CMD_NONE   = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PREP, S_FETCH, S_SEND, S_HOLD, S_GAP
  } seq_st_e;

  typedef enum logic [2:0] {
    F_CMD, F_ADDR, F_DATA, F_TRAIL, F_PAD
  } fld_e;

  localparam logic [7:0] OP_FRAME  = 8'h80;
  localparam logic [7:0] OP_CLEAR  = 8'h20;
  localparam logic [7:0] OP_FREEZE = 8'h00;
  localparam logic [7:0] OP_FILL   = 8'h00;

  function automatic logic [7:0] bitrev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

endpackage

// File: rtl/memlcd_shift.sv
module memlcd_shift #(
  parameter int CLK_DIV = 8,
  localparam int HALF  = CLK_DIV / 2,
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       sclk,
  output logic       si,
  output logic       done
);

  logic             act_q, act_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             last_div;

  assign last_div = (div_q == DIV_W'(CLK_DIV - 1));
  assign done     = act_q && last_div && (bit_q == 3'd0);
  assign sclk     = act_q && (div_q >= DIV_W'(HALF));
  assign si       = act_q && sh_q[7];

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    div_d = div_q;
    if (!act_q) begin
      if (load) begin
        act_d = 1'b1;
        sh_d  = din;
        bit_d = 3'd7;
        div_d = '0;
      end
    end else if (last_div) begin
      div_d = '0;
      if (bit_q == 3'd0) begin
        act_d = 1'b0;
      end else begin
        bit_d = bit_q - 3'd1;
        sh_d  = {sh_q[6:0], 1'b0};
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      bit_q <= '0;
      div_q <= '0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/memlcd_vcom.sv
module memlcd_vcom #(
  parameter int VCOM_PRE   = 250,
  parameter int VCOM_TICKS = 64000,
  localparam int PRE_W  = (VCOM_PRE > 1) ? $clog2(VCOM_PRE) : 1,
  localparam int TICK_W = (VCOM_TICKS > 1) ? $clog2(VCOM_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic vcom
);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              tick_en;

  assign tick_en = (pre_q == PRE_W'(VCOM_PRE - 1));
  assign vcom    = (tick_q == TICK_W'(VCOM_TICKS - 1));

  always_comb begin
    pre_d  = tick_en ? '0 : pre_q + PRE_W'(1);
    tick_d = vcom ? '0 : tick_q + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q <= pre_d;
      if (tick_en) tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/memlcd_seq.sv
module memlcd_seq
  import memlcd_pkg::*;
#(
  parameter int LINES      = 168,
  parameter int LINE_BYTES = 18,
  parameter int SETUP_CYC  = 112,
  parameter int HOLD_CYC   = 112,
  parameter int GAP_CYC    = 64,
  localparam int ROW_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BYTE_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1,
  localparam int WMAX   = (SETUP_CYC > HOLD_CYC) ?
                          ((SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC) :
                          ((HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC),
  localparam int WAIT_W = $clog2(WMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic              cmd_ready,
  output logic              busy,
  output logic              fb_rd_en,
  output logic [ROW_W-1:0]  fb_row,
  output logic [BYTE_W-1:0] fb_byte,
  input  logic [7:0]        fb_data,
  output logic              sh_load,
  output logic [7:0]        sh_din,
  input  logic              sh_done,
  output logic              cs
);

  seq_st_e           state_q, state_d;
  fld_e              fld_q, fld_d;
  cmd_e              kind_q, kind_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [1:0]        pad_q, pad_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              cs_q, cs_d;
  logic [7:0]        tx_byte;

  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign fb_row    = row_q;
  assign fb_byte   = byte_q;
  assign cs        = cs_q;

  always_comb begin
    tx_byte = OP_FILL;
    case (fld_q)
      F_CMD: begin
        case (kind_q)
          CMD_FRAME: tx_byte = OP_FRAME;
          CMD_CLEAR: tx_byte = OP_CLEAR;
          default:   tx_byte = OP_FREEZE;
        endcase
      end
      F_ADDR:  tx_byte = bitrev8(8'(LINES) - 8'(row_q));
      default: tx_byte = OP_FILL;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    fld_d    = fld_q;
    kind_d   = kind_q;
    row_d    = row_q;
    byte_d   = byte_q;
    pad_d    = pad_q;
    wait_d   = wait_q;
    sh_load  = 1'b0;
    sh_din   = tx_byte;
    fb_rd_en = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid && (cmd_code != CMD_NONE)) begin
          kind_d  = cmd_e'(cmd_code);
          fld_d   = F_CMD;
          wait_d  = '0;
          state_d = S_SETUP;
        end
      end
      S_SETUP: begin
        if (wait_q == WAIT_W'(SETUP_CYC - 1)) state_d = S_PREP;
        else wait_d = wait_q + WAIT_W'(1);
      end
      S_PREP: begin
        if (fld_q == F_DATA) begin
          fb_rd_en = 1'b1;
          state_d  = S_FETCH;
        end else begin
          sh_load = 1'b1;
          state_d = S_SEND;
        end
      end
      S_FETCH: begin
        sh_load = 1'b1;
        sh_din  = fb_data;
        state_d = S_SEND;
      end
      S_SEND: begin
        if (sh_done) begin
          state_d = S_PREP;
          case (fld_q)
            F_CMD: begin
              if (kind_q == CMD_FRAME) begin
                fld_d = F_ADDR;
                row_d = '0;
              end else begin
                fld_d = F_PAD;
                pad_d = (kind_q == CMD_FREEZE) ? 2'd2 : 2'd1;
              end
            end
            F_ADDR: begin
              fld_d  = F_DATA;
              byte_d = BYTE_W'(LINE_BYTES - 1);
            end
            F_DATA: begin
              if (byte_q == '0) fld_d = F_TRAIL;
              else byte_d = byte_q - BYTE_W'(1);
            end
            F_TRAIL: begin
              if (row_q == ROW_W'(LINES - 1)) begin
                fld_d = F_PAD;
                pad_d = 2'd1;
              end else begin
                row_d = row_q + ROW_W'(1);
                fld_d = F_ADDR;
              end
            end
            default: begin
              if (pad_q == 2'd1) begin
                state_d = S_HOLD;
                wait_d  = '0;
              end else begin
                pad_d = pad_q - 2'd1;
              end
            end
          endcase
        end
      end
      S_HOLD: begin
        if (wait_q == WAIT_W'(HOLD_CYC - 1)) begin
          state_d = S_GAP;
          wait_d  = '0;
        end else begin
          wait_d = wait_q + WAIT_W'(1);
        end
      end
      default: begin
        if (wait_q == WAIT_W'(GAP_CYC - 1)) state_d = S_IDLE;
        else wait_d = wait_q + WAIT_W'(1);
      end
    endcase
    cs_d = (state_d != S_IDLE) && (state_d != S_GAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fld_q   <= F_CMD;
      kind_q  <= CMD_NONE;
      row_q   <= '0;
      byte_q  <= '0;
      pad_q   <= '0;
      wait_q  <= '0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fld_q   <= fld_d;
      kind_q  <= kind_d;
      row_q   <= row_d;
      byte_q  <= byte_d;
      pad_q   <= pad_d;
      wait_q  <= wait_d;
      cs_q    <= cs_d;
    end
  end

endmodule

// File: rtl/memlcd_ctrl.sv
module memlcd_ctrl #(
  parameter int LINES      = 168,
  parameter int LINE_BYTES = 18,
  parameter int CLK_DIV    = 8,
  parameter int SETUP_CYC  = 112,
  parameter int HOLD_CYC   = 112,
  parameter int GAP_CYC    = 64,
  parameter int VCOM_PRE   = 250,
  parameter int VCOM_TICKS = 64000,
  localparam int ROW_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BYTE_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic              cmd_ready,
  output logic              busy,
  output logic              fb_rd_en,
  output logic [ROW_W-1:0]  fb_row,
  output logic [BYTE_W-1:0] fb_byte,
  input  logic [7:0]        fb_data,
  output logic              lcd_sclk,
  output logic              lcd_si,
  output logic              lcd_cs,
  output logic              lcd_vcom,
  output logic              lcd_en
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sh_load;
  logic [7:0] sh_din;
  logic       sh_done;
  logic       en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) en_q <= 1'b0;
    else            en_q <= 1'b1;
  end
  assign lcd_en = en_q;

  memlcd_seq #(
    .LINES(LINES), .LINE_BYTES(LINE_BYTES),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .busy(busy),
    .fb_rd_en(fb_rd_en), .fb_row(fb_row), .fb_byte(fb_byte), .fb_data(fb_data),
    .sh_load(sh_load), .sh_din(sh_din), .sh_done(sh_done),
    .cs(lcd_cs)
  );

  memlcd_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .load(sh_load), .din(sh_din),
    .sclk(lcd_sclk), .si(lcd_si), .done(sh_done)
  );

  memlcd_vcom #(.VCOM_PRE(VCOM_PRE), .VCOM_TICKS(VCOM_TICKS)) u_vcom (
    .clk(clk), .rst_n(rst_int_n), .vcom(lcd_vcom)
  );

endmodule

// File: rtl/memlcd_chk.sv
module memlcd_chk #(
  parameter int CLK_DIV  = 8,
  parameter int VCOM_PRE = 250
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic fb_rd_en,
  input logic lcd_sclk,
  input logic lcd_si,
  input logic lcd_cs,
  input logic lcd_vcom,
  input logic lcd_en
);

  int unsigned sclk_hi_q;
  int unsigned vcom_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_hi_q <= 0;
      vcom_hi_q <= 0;
    end else begin
      sclk_hi_q <= lcd_sclk ? sclk_hi_q + 1 : 0;
      vcom_hi_q <= lcd_vcom ? vcom_hi_q + 1 : 0;
    end
  end

  assert_sclk_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs |-> !lcd_sclk);

  assert_sclk_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_sclk) |-> sclk_hi_q == CLK_DIV / 2);

  assert_si_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_si));

  assert_read_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> lcd_cs);

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready != busy);

  assert_cs_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs) |-> $past(cmd_valid && cmd_ready));

  assert_vcom_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_vcom) |-> vcom_hi_q == VCOM_PRE);

  assert_enable_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lcd_en);

endmodule

bind memlcd_ctrl memlcd_chk #(.CLK_DIV(CLK_DIV), .VCOM_PRE(VCOM_PRE)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .busy(busy),
  .fb_rd_en(fb_rd_en), .lcd_sclk(lcd_sclk), .lcd_si(lcd_si),
  .lcd_cs(lcd_cs), .lcd_vcom(lcd_vcom), .lcd_en(lcd_en)
);

// File: tb/memlcd_ctrl_bench.sv
module memlcd_ctrl_bench;

  localparam int CLK_P  = 10;
  localparam int LN     = 4;
  localparam int LB     = 3;
  localparam int DIV    = 4;
  localparam int SETUP  = 5;
  localparam int HOLD   = 6;
  localparam int GAP    = 3;
  localparam int PRE    = 3;
  localparam int TICKS  = 10;
  localparam int FRAME_N = 1 + LN * (LB + 2) + 1;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_code;
  logic       cmd_ready, busy, fb_rd_en;
  logic [1:0] fb_row;
  logic [1:0] fb_byte;
  logic [7:0] fb_data;
  logic       lcd_sclk, lcd_si, lcd_cs, lcd_vcom, lcd_en;

  memlcd_ctrl #(
    .LINES(LN), .LINE_BYTES(LB), .CLK_DIV(DIV),
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .GAP_CYC(GAP),
    .VCOM_PRE(PRE), .VCOM_TICKS(TICKS)
  ) u_memlcd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .busy(busy), .fb_rd_en(fb_rd_en),
    .fb_row(fb_row), .fb_byte(fb_byte), .fb_data(fb_data),
    .lcd_sclk(lcd_sclk), .lcd_si(lcd_si), .lcd_cs(lcd_cs),
    .lcd_vcom(lcd_vcom), .lcd_en(lcd_en)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] seed = 8'h00;

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input logic [7:0] s, input int r, input int b);
    return (s + 8'(r * 37) + 8'(b * 11)) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] rev(input logic [7:0] v);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) o[k] = v[7-k];
    return o;
  endfunction

  always @(posedge clk) if (fb_rd_en) fb_data <= pat(seed, int'(fb_row), int'(fb_byte));

  // serial decoder and interval monitor
  logic [7:0] log_b [0:255];
  int nlog = 0, cs_rises = 0, nbits = 0;
  logic [7:0] cur = 8'h00;
  logic p_sclk = 1'b0, p_cs = 1'b0, p_vcom = 1'b0, p_si = 1'b0;
  int t_cs_rise = 0, t_cs_fall = 0, t_sr = 0, t_sf = 0, t_vr = 0;
  bit have_cs_fall = 0, first_sclk = 0, have_vr = 0;
  int e_setup = 0, e_hold = 0, e_gap = 0, e_high = 0, e_si = 0, e_part = 0;
  int e_rd = 0, e_vcom = 0, vcom_rises = 0, n_timed = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fb_rd_en && !lcd_cs) e_rd++;
      if (lcd_cs && !p_cs) begin
        cs_rises++;
        if (have_cs_fall && (cyc - t_cs_fall) < GAP) e_gap++;
        t_cs_rise = cyc; first_sclk = 1; nbits = 0;
      end
      if (!lcd_cs && p_cs) begin
        if ((cyc - t_sf) < HOLD) e_hold++;
        if (nbits != 0) e_part++;
        t_cs_fall = cyc; have_cs_fall = 1; n_timed++;
      end
      if (lcd_sclk && !p_sclk) begin
        if (first_sclk && (cyc - t_cs_rise) < SETUP) e_setup++;
        first_sclk = 0; t_sr = cyc;
        cur = {cur[6:0], lcd_si}; nbits++;
        if (nbits == 8) begin
          log_b[nlog[7:0]] = cur; nlog++; nbits = 0;
        end
      end
      if (!lcd_sclk && p_sclk) begin
        if ((cyc - t_sr) != DIV / 2) e_high++;
        t_sf = cyc;
      end
      if (lcd_sclk && p_sclk && (lcd_si != p_si)) e_si++;
      if (lcd_vcom && !p_vcom) begin
        if (have_vr && (cyc - t_vr) != PRE * TICKS) e_vcom++;
        have_vr = 1; t_vr = cyc; vcom_rises++;
      end
      if (!lcd_vcom && p_vcom && (cyc - t_vr) != PRE) e_vcom++;
    end
    p_sclk = lcd_sclk; p_cs = lcd_cs; p_vcom = lcd_vcom; p_si = lcd_si;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit saw_wait = 0;

  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    while (!cmd_ready) begin
      saw_wait = 1;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] s);
    int base, r0, k;
    logic [7:0] e;
    string tg;
    seed = s; base = nlog; r0 = cs_rises;
    issue(2'd0);
    wait_idle();
    check(nlog - base == FRAME_N, "R3", "frame byte count", nlog - base, FRAME_N);
    check(cs_rises - r0 == 1, "R3", "frame windows", cs_rises - r0, 1);
    for (int i = 0; i < FRAME_N; i++) begin
      if (i == 0) begin e = 8'h80; tg = "R3"; end
      else if (i == FRAME_N - 1) begin e = 8'h00; tg = "R3"; end
      else begin
        k = (i - 1) % (LB + 2);
        if (k == 0) begin e = rev(8'(LN - (i - 1) / (LB + 2))); tg = "R4"; end
        else if (k <= LB) begin e = pat(s, (i - 1) / (LB + 2), LB - k); tg = "R5"; end
        else begin e = 8'h00; tg = "R3"; end
      end
      check(log_b[8'(base + i)] == e, tg, $sformatf("frame byte %0d", i),
            int'(log_b[8'(base + i)]), int'(e));
    end
  endtask

  task automatic run_short(input logic [1:0] c, input int n, input logic [7:0] op,
                           input string tg);
    int base, r0;
    base = nlog; r0 = cs_rises;
    issue(c);
    wait_idle();
    check(nlog - base == n, tg, "byte count", nlog - base, n);
    check(cs_rises - r0 == 1, tg, "windows", cs_rises - r0, 1);
    for (int i = 0; i < n; i++)
      check(log_b[8'(base + i)] == ((i == 0) ? op : 8'h00), tg, "byte value",
            int'(log_b[8'(base + i)]), (i == 0) ? int'(op) : 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base, r0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!lcd_cs && !lcd_sclk && !lcd_si, "R1", "serial pins in reset",
          {lcd_cs, lcd_sclk, lcd_si}, 0);
    check(!lcd_vcom && !lcd_en, "R1", "vcom/en in reset", {lcd_vcom, lcd_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(lcd_en == 1'b1, "R12", "enable after reset", lcd_en, 1);

    run_frame(8'h00);
    run_frame(8'h5C);
    run_frame(8'hFF);
    run_short(2'd1, 2, 8'h20, "R6");
    run_short(2'd2, 3, 8'h00, "R7");

    // R8 reserved code discarded
    base = nlog; r0 = cs_rises;
    issue(2'd3);
    repeat (20) @(negedge clk);
    check(cs_rises == r0 && nlog == base, "R8", "windows after code 3",
          cs_rises - r0, 0);
    check(cmd_ready == 1'b1, "R8", "ready after code 3", cmd_ready, 1);

    // R10 command held off while busy
    base = nlog; r0 = cs_rises; saw_wait = 0;
    issue(2'd1);
    issue(2'd2);
    wait_idle();
    check(saw_wait == 1, "R10", "second command stalled", saw_wait, 1);
    check(cs_rises - r0 == 2, "R10", "queued windows", cs_rises - r0, 2);
    check(nlog - base == 5, "R10", "queued bytes", nlog - base, 5);
    for (int i = 0; i < 5; i++)
      check(log_b[8'(base + i)] == ((i == 0) ? 8'h20 : 8'h00), "R10", "queued byte",
            int'(log_b[8'(base + i)]), (i == 0) ? 32 : 0);

    repeat (2 * PRE * TICKS) @(negedge clk);
    check(e_high == 0 && e_si == 0 && e_part == 0, "R2", "serial format errors",
          e_high + e_si + e_part, 0);
    check(e_setup == 0, "R9", "setup violations", e_setup, 0);
    check(e_hold == 0, "R9", "hold violations", e_hold, 0);
    check(e_gap == 0 && n_timed >= 7, "R9", "gap violations", e_gap, 0);
    check(e_rd == 0, "R5", "reads outside window", e_rd, 0);
    check(e_vcom == 0, "R11", "vcom interval errors", e_vcom, 0);
    check(vcom_rises >= 10, "R11", "vcom pulses seen", vcom_rises, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule